// File: doc/BRIEF.md
# Host Port Transmit Path

This block carries 32-bit words from a local processor to an external host through two register stages. The local side writes a word into a transmit holding stage. Whenever the holding stage has a word and the host-side receive stage is empty, the word moves into the receive stage on its own, without any request from either side. The host then reads the word and acknowledges it with a read strobe. One flag on each stage tracks its state. The local side sees the holding stage's empty flag and can enable an interrupt on it. The host sees the receive stage's full flag.

A small control register holds the interrupt enable, two host flag bits shown to the host, and an interface-hold bit. The hold bit is set by every reset. While it is set, the path is frozen in its reset state. A host-side initialization command can force either flag back to its idle value, one direction at a time.

Top module: `host_tx_path`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `tx_empty`=1, `host_rxf`=0, `tx_irq`=0, `host_hf`=0 and `host_rdata`=0, and the hold bit is 1.
- R2: A control write (`ctl_we`=1) loads the enable, hold and host flag fields at the rising edge. `host_hf` shows the new flag field after that edge.
- R3: With hold=0, a local write (`loc_we`=1) stores `loc_wdata` and leaves `tx_empty`=0 after the edge.
- R4: `tx_irq` is 1 exactly when the stored enable bit is 1 and `tx_empty`=1.
- R5: With hold=0, at any edge where `tx_empty`=0 and `host_rxf`=0 before the edge, the held word appears on `host_rdata`. After that edge `host_rxf`=1 and `tx_empty`=1, unless a local write occurs at the same edge. While `host_rxf`=1, the word waits in the holding stage.
- R6: With hold=0, a host read (`host_re`=1) while `host_rxf`=1 leaves `host_rxf`=0 after the edge. A waiting word then moves at the next edge.
- R7: A local write while `tx_empty`=0 replaces the held word and keeps `tx_empty`=0. Only the last word written is delivered.
- R8: While hold=1, local writes, host reads and initialization commands have no effect. The flags stay at `tx_empty`=1 and `host_rxf`=0. A control write with the hold field at 1 returns both flags to those values at that edge.
- R9: A software reset pulse (`sw_rst`=1) has priority over a control write in the same cycle. It clears the enable and host flag bits, sets hold to 1, sets `tx_empty`=1 and clears `host_rxf` at the edge. It leaves `host_rdata` unchanged.
- R10: With hold=0, an initialization command (`init_req`=1) with `init_rx_dir`=1 sets `tx_empty`=1. With `init_tx_dir`=1 it clears `host_rxf`. Both take priority over a local write, a transfer or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_rst | input | 1 | Software reset pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_ien | input | 1 | Transmit interrupt enable value to write |
| ctl_hold | input | 1 | Interface-hold value to write |
| ctl_hf | input | 2 | Host flag value to write |
| loc_we | input | 1 | Local write strobe into the holding stage |
| loc_wdata | input | 32 | Local write data |
| tx_empty | output | 1 | Holding stage empty flag |
| tx_irq | output | 1 | Transmit interrupt |
| host_re | input | 1 | Host read acknowledge strobe |
| host_rdata | output | 32 | Receive stage contents |
| host_rxf | output | 1 | Receive stage full flag |
| host_hf | output | 2 | Host flag bits from the control register |
| init_req | input | 1 | Initialization command strobe |
| init_rx_dir | input | 1 | Initialization acts on the local-side empty flag |
| init_tx_dir | input | 1 | Initialization acts on the host-side full flag |

## Verification
The bound checker tests the per-cycle rules on every edge. These rules are: a write clears the empty flag, a transfer happens when both flags are clear, a read clears the full flag, and the interrupt implies the empty flag. It also checks that the flags stay at their idle values while hold is set, and the effect of software reset on the control bits. Some behaviour shows only in the bench's ordered scenarios. These are: which word survives an overwrite, that a stalled word is delivered one edge after the host's read, and how an initialization command competes with a write in the same cycle. The asynchronous reset taking effect between clock edges is also checked only by the bench.

// File: rtl/hptx_pkg.sv
package hptx_pkg;
  parameter int unsigned HPTX_DATA_W = 32;
  parameter int unsigned HPTX_HF_W   = 2;

  typedef struct packed {
    logic                 ien;
    logic                 hold;
    logic [HPTX_HF_W-1:0] hf;
  } hptx_ctl_t;

  localparam hptx_ctl_t HPTX_CTL_RST = '{ien: 1'b0, hold: 1'b1, hf: '0};
endpackage

// File: rtl/hptx_ctl_reg.sv
module hptx_ctl_reg
  import hptx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_rst,
  input  logic      wr_en,
  input  hptx_ctl_t wr_val,
  output hptx_ctl_t ctl_q
);
  hptx_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (sw_rst)     ctl_d = HPTX_CTL_RST;
    else if (wr_en) ctl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= HPTX_CTL_RST;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/hptx_hold_stage.sv
module hptx_hold_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              set_empty,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drain,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q
);
  logic              empty_d;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    empty_d = empty_q;
    if (flush)          empty_d = 1'b1;
    else if (set_empty) empty_d = 1'b1;
    else if (load)      empty_d = 1'b0;
    else if (drain)     empty_d = 1'b1;
  end

  assign data_en = load & ~flush;
  assign data_d  = data_en ? load_data : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      data_q  <= '0;
    end else begin
      empty_q <= empty_d;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/hptx_rx_stage.sv
module hptx_rx_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              clr_full,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              consume,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    full_d = full_q;
    if (flush)         full_d = 1'b0;
    else if (clr_full) full_d = 1'b0;
    else if (fill)     full_d = 1'b1;
    else if (consume)  full_d = 1'b0;
  end

  assign data_d = fill ? fill_data : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/host_tx_path.sv
module host_tx_path
  import hptx_pkg::*;
#(
  parameter int unsigned DATA_W = HPTX_DATA_W,
  parameter int unsigned HF_W   = HPTX_HF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              ctl_we,
  input  logic              ctl_ien,
  input  logic              ctl_hold,
  input  logic [HF_W-1:0]   ctl_hf,
  input  logic              loc_we,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic              tx_empty,
  output logic              tx_irq,
  input  logic              host_re,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rxf,
  output logic [HF_W-1:0]   host_hf,
  input  logic              init_req,
  input  logic              init_rx_dir,
  input  logic              init_tx_dir
);
  hptx_ctl_t         ctl_wr;
  hptx_ctl_t         ctl_q;
  logic              active;
  logic              flush;
  logic              xfer;
  logic [DATA_W-1:0] txh_q;
  logic              hold_q;
  logic              ien_q;

  assign ctl_wr = '{ien: ctl_ien, hold: ctl_hold, hf: ctl_hf};

  hptx_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_rst (sw_rst),
    .wr_en  (ctl_we),
    .wr_val (ctl_wr),
    .ctl_q  (ctl_q)
  );

  assign hold_q = ctl_q.hold;
  assign ien_q  = ctl_q.ien;
  assign active = ~hold_q;
  assign flush  = sw_rst | (ctl_we & ctl_hold);
  assign xfer   = active & ~flush & ~tx_empty & ~host_rxf &
                  ~(init_req & init_tx_dir);

  hptx_hold_stage #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .set_empty (active & init_req & init_rx_dir),
    .load      (active & loc_we),
    .load_data (loc_wdata),
    .drain     (xfer),
    .data_q    (txh_q),
    .empty_q   (tx_empty)
  );

  hptx_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .clr_full  (active & init_req & init_tx_dir),
    .fill      (xfer),
    .fill_data (txh_q),
    .consume   (active & host_re & host_rxf),
    .data_q    (host_rdata),
    .full_q    (host_rxf)
  );

  assign tx_irq  = ien_q & tx_empty;
  assign host_hf = ctl_q.hf;
endmodule

// File: rtl/host_tx_path_chk.sv
module host_tx_path_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HF_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic              ctl_we,
  input logic              ctl_hold,
  input logic              loc_we,
  input logic [DATA_W-1:0] loc_wdata,
  input logic              tx_empty,
  input logic              tx_irq,
  input logic              host_re,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rxf,
  input logic [HF_W-1:0]   host_hf,
  input logic              init_req,
  input logic              init_rx_dir,
  input logic              init_tx_dir,
  input logic              hold_q,
  input logic              ien_q,
  input logic [DATA_W-1:0] txh_q
);
  logic quiet;
  assign quiet = ~sw_rst & ~(ctl_we & ctl_hold) & ~hold_q;

  // R3
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && loc_we && !(init_req && init_rx_dir)) |=> !tx_empty);

  // R7
  overwrite_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && loc_we) |=> (txh_q == $past(loc_wdata)));

  // R5
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !init_req && !tx_empty && !host_rxf) |=>
      (host_rxf && host_rdata == $past(txh_q)));

  // R5
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rxf && !host_re && !sw_rst && !ctl_we && !init_req) |=>
      ($stable(host_rdata) && host_rxf));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && host_rxf && host_re) |=> !host_rxf);

  // R4
  irq_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_empty && ien_q));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (tx_empty && !host_rxf));

  // R9
  swrst_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (hold_q && !ien_q && host_hf == '0 && !tx_irq));

  // R10
  init_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && init_req && init_rx_dir) |=> tx_empty);

  // R10
  init_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && init_req && init_tx_dir) |=> !host_rxf);
endmodule

bind host_tx_path host_tx_path_chk #(.DATA_W(DATA_W), .HF_W(HF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_rst      (sw_rst),
  .ctl_we      (ctl_we),
  .ctl_hold    (ctl_hold),
  .loc_we      (loc_we),
  .loc_wdata   (loc_wdata),
  .tx_empty    (tx_empty),
  .tx_irq      (tx_irq),
  .host_re     (host_re),
  .host_rdata  (host_rdata),
  .host_rxf    (host_rxf),
  .host_hf     (host_hf),
  .init_req    (init_req),
  .init_rx_dir (init_rx_dir),
  .init_tx_dir (init_tx_dir),
  .hold_q      (hold_q),
  .ien_q       (ien_q),
  .txh_q       (txh_q)
);

// File: tb/host_tx_path_tb_top.sv
module host_tx_path_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        ctl_we = 1'b0;
  logic        ctl_ien = 1'b0;
  logic        ctl_hold = 1'b0;
  logic [1:0]  ctl_hf = '0;
  logic        loc_we = 1'b0;
  logic [31:0] loc_wdata = '0;
  logic        host_re = 1'b0;
  logic        init_req = 1'b0;
  logic        init_rx_dir = 1'b0;
  logic        init_tx_dir = 1'b0;
  logic        tx_empty, tx_irq, host_rxf;
  logic [31:0] host_rdata;
  logic [1:0]  host_hf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  host_tx_path dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .ctl_we(ctl_we), .ctl_ien(ctl_ien), .ctl_hold(ctl_hold), .ctl_hf(ctl_hf),
    .loc_we(loc_we), .loc_wdata(loc_wdata),
    .tx_empty(tx_empty), .tx_irq(tx_irq),
    .host_re(host_re), .host_rdata(host_rdata), .host_rxf(host_rxf),
    .host_hf(host_hf),
    .init_req(init_req), .init_rx_dir(init_rx_dir), .init_tx_dir(init_tx_dir)
  );

  typedef struct packed {
    logic        cwe;
    logic        ien;
    logic        hold;
    logic [1:0]  hf;
    logic        we;
    logic [31:0] wd;
    logic        re;
    logic        ini;
    logic        ird;
    logic        itd;
    logic        e_te;
    logic        e_rf;
    logic        e_irq;
    logic [31:0] e_d;
    logic [1:0]  e_hf;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    // R2 R4: release hold, enable irq, flags 10
    '{1'b1,1'b1,1'b0,2'b10, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,32'h0,         2'b10,4'd2},
    // R3: first word
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'hA1A1_0001, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,32'h0,         2'b10,4'd3},
    // R5: automatic move
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,32'hA1A1_0001, 2'b10,4'd5},
    // R3: second word, receive stage full
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'hB2B2_0002, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,32'hA1A1_0001, 2'b10,4'd3},
    // R7: overwrite
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'hC3C3_0003, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,32'hA1A1_0001, 2'b10,4'd7},
    // R5: stall
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,32'hA1A1_0001, 2'b10,4'd5},
    // R6: host read
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,32'hA1A1_0001, 2'b10,4'd6},
    // R6 R7: waiting word (last written) moves
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,32'hC3C3_0003, 2'b10,4'd6},
    // R4: disable irq, flags 01
    '{1'b1,1'b0,1'b0,2'b01, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,32'hC3C3_0003, 2'b01,4'd4},
    // R6: write and read together
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'hD4D4_0004, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,32'hC3C3_0003, 2'b01,4'd6},
    // R5
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,32'hD4D4_0004, 2'b01,4'd5},
    // R10: init host direction clears full
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0,32'hD4D4_0004, 2'b01,4'd10},
    // R3
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'hE5E5_0005, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,32'hD4D4_0004, 2'b01,4'd3},
    // R10: init local direction beats write; held word still moves
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'hF6F6_0006, 1'b0,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b0,32'hE5E5_0005, 2'b01,4'd10},
    // R8: write hold=1 returns flags to idle
    '{1'b1,1'b1,1'b1,2'b11, 1'b0,32'h0,         1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,32'hE5E5_0005, 2'b11,4'd8},
    // R8: write ignored
    '{1'b0,1'b0,1'b0,2'b00, 1'b1,32'h7777_7777, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,32'hE5E5_0005, 2'b11,4'd8},
    // R8: read and init ignored
    '{1'b0,1'b0,1'b0,2'b00, 1'b0,32'h0,         1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,32'hE5E5_0005, 2'b11,4'd8}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_rst = 0; ctl_we = 0; ctl_ien = 0; ctl_hold = 0; ctl_hf = '0;
    loc_we = 0; loc_wdata = '0; host_re = 0;
    init_req = 0; init_rx_dir = 0; init_tx_dir = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", "tx_empty", {31'b0, tx_empty}, 32'd1);
    chk("R1", "host_rxf", {31'b0, host_rxf}, 32'd0);
    chk("R1", "tx_irq",   {31'b0, tx_irq},   32'd0);
    chk("R1", "host_hf",  {30'b0, host_hf},  32'd0);
    chk("R1", "host_rdata", host_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d row%0d", VEC[i].tag, i);
      ctl_we = VEC[i].cwe; ctl_ien = VEC[i].ien; ctl_hold = VEC[i].hold;
      ctl_hf = VEC[i].hf; loc_we = VEC[i].we; loc_wdata = VEC[i].wd;
      host_re = VEC[i].re; init_req = VEC[i].ini;
      init_rx_dir = VEC[i].ird; init_tx_dir = VEC[i].itd;
      @(negedge clk);
      idle_inputs();
      chk(r, "tx_empty", {31'b0, tx_empty}, {31'b0, VEC[i].e_te});
      chk(r, "host_rxf", {31'b0, host_rxf}, {31'b0, VEC[i].e_rf});
      chk(r, "tx_irq",   {31'b0, tx_irq},   {31'b0, VEC[i].e_irq});
      chk(r, "host_rdata", host_rdata, VEC[i].e_d);
      chk(r, "host_hf", {30'b0, host_hf}, {30'b0, VEC[i].e_hf});
    end

    // R9: release hold, load a word, then software reset beats a control write
    ctl_we = 1; ctl_ien = 1; ctl_hold = 0; ctl_hf = 2'b11;
    @(negedge clk); idle_inputs();
    loc_we = 1; loc_wdata = 32'h1234_5678;
    @(negedge clk); idle_inputs();
    @(negedge clk);
    chk("R9", "pre host_rxf", {31'b0, host_rxf}, 32'd1);
    sw_rst = 1; ctl_we = 1; ctl_ien = 1; ctl_hold = 0; ctl_hf = 2'b10;
    @(negedge clk); idle_inputs();
    chk("R9", "tx_empty", {31'b0, tx_empty}, 32'd1);
    chk("R9", "host_rxf", {31'b0, host_rxf}, 32'd0);
    chk("R9", "tx_irq",   {31'b0, tx_irq},   32'd0);
    chk("R9", "host_hf",  {30'b0, host_hf},  32'd0);
    chk("R9", "rdata kept", host_rdata, 32'h1234_5678);
    loc_we = 1; loc_wdata = 32'h5555_AAAA;
    @(negedge clk); idle_inputs();
    chk("R9", "hold after reset", {31'b0, tx_empty}, 32'd1);

    // R1: asynchronous reset mid-operation
    ctl_we = 1; ctl_hold = 0; ctl_ien = 1;
    @(negedge clk); idle_inputs();
    loc_we = 1; loc_wdata = 32'h0BAD_F00D;
    @(negedge clk); idle_inputs();
    @(negedge clk);
    chk("R1", "pre host_rxf", {31'b0, host_rxf}, 32'd1);
    #3 rst_n = 1'b0;
    #1;
    chk("R1", "async tx_empty", {31'b0, tx_empty}, 32'd1);
    chk("R1", "async host_rxf", {31'b0, host_rxf}, 32'd0);
    chk("R1", "async rdata", host_rdata, 32'd0);
    chk("R1", "async tx_irq", {31'b0, tx_irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    loc_we = 1; loc_wdata = 32'h4444_4444;
    @(negedge clk); idle_inputs();
    chk("R1", "hold after reset", {31'b0, tx_empty}, 32'd1);
    finish_run();
  end
endmodule